// File: doc/BRIEF.md
# Serial Controller FIFO Pair with Self-Sizing Watermark

This block holds the byte buffers that sit between a processor register bus and a serial shift engine. Software writes transmit bytes into one FIFO through a write-only data address and reads received bytes out of a second FIFO through a read-only data address. The shift engine takes transmit bytes from the head of the first FIFO and delivers received bytes into the second. For every byte it shifts out, it delivers one byte back.

A programmable transmit watermark drives a below-watermark level, which the refill logic uses to top up the transmit FIFO. The watermark register has only as many bits as are needed to hold depth minus one, and upper write bits are dropped. Software can therefore learn the FIFO depth by writing all ones and reading the value back. The block also reports transmit-full, receive-not-empty and a sticky transmit-overflow level. `DEPTH` must be a power of two.

Top module: `ser_fifo_bank`

## Requirements
- R1: Bus addresses are 0x1C for a transmit push (write only), 0x20 for a receive pop (read only) and 0x28 for the watermark (read/write). A read of any other address, including 0x1C, returns zero. A write to 0x20 or to an unmapped address changes no state.
- R2: The watermark holds only log2(DEPTH) bits. A write keeps the low bits and drops the rest, so writing 0xFFFF and then reading returns DEPTH-1. Reads are zero-extended to 16 bits.
- R3: After reset the watermark reads 1, both FIFOs are empty, tx_below_wm_o is 1, and tx_full_o, rx_not_empty_o and tx_overflow_o are 0.
- R4: tx_below_wm_o is 1 exactly when the transmit occupancy is less than the watermark value.
- R5: tx_full_o is 1 exactly when the transmit FIFO holds DEPTH bytes. A push while full is dropped and sets tx_overflow_o, which stays 1 until reset.
- R6: eng_tx_data_o shows the oldest transmit byte, and eng_tx_pop_i removes it, so bytes leave in push order. A pop on an empty transmit FIFO has no effect.
- R7: rx_not_empty_o is 1 while any received byte is stored. A read of 0x20 returns the head byte in the same access and removes exactly that one byte.
- R8: A read of 0x20 while the receive FIFO is empty returns zero and leaves the FIFO unchanged.
- R9: A byte delivered by the engine while the receive FIFO is full is discarded, and the stored bytes keep their order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, valid in the access cycle |
| eng_tx_pop_i | input | 1 | Engine takes the transmit head byte |
| eng_tx_data_o | output | 8 | Transmit head byte |
| eng_rx_push_i | input | 1 | Engine delivers a received byte |
| eng_rx_data_i | input | 8 | Received byte |
| tx_below_wm_o | output | 1 | Transmit occupancy below watermark |
| tx_full_o | output | 1 | Transmit FIFO full |
| tx_overflow_o | output | 1 | Sticky: a transmit push was dropped |
| rx_not_empty_o | output | 1 | Receive FIFO holds data |

## Verification
A pointer or count that drifts inside either FIFO shows up at the ports within one access. A bad count makes tx_below_wm_o or tx_full_o flip at the wrong fill level in the watermark-by-occupancy sweep. A bad read pointer returns a byte out of order, or returns zero, on the next pop. A watermark register of the wrong width is exposed by the first read after an oversized write. A receive FIFO that accepts a byte while full hands back a wrong byte on the last read of the drain, or leaves rx_not_empty_o high one read too long.

// File: rtl/ser_fifo_pkg.sv
package ser_fifo_pkg;
  localparam int ADDR_W = 8;
  localparam int REG_W  = 16;
  localparam int BYTE_W = 8;
  localparam logic [ADDR_W-1:0] A_TXD = 8'h1C;
  localparam logic [ADDR_W-1:0] A_RXD = 8'h20;
  localparam logic [ADDR_W-1:0] A_WM  = 8'h28;
endpackage

// File: rtl/ser_fifo_core.sv
module ser_fifo_core #(
  parameter int DEPTH = 8,
  parameter int W     = 8,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     din_i,
  input  logic             pop_i,
  output logic [W-1:0]     dout_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign count_o = cnt_q;
  assign dout_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (do_push) begin
      mem_q[wr_q] <= din_i;
    end
  end
endmodule

// File: rtl/ser_wm_reg.sv
module ser_wm_reg #(
  parameter int DEPTH = 8,
  localparam int WM_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_i,
  input  logic [WM_W-1:0] wdata_i,
  output logic [WM_W-1:0] wm_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   wm_o <= WM_W'(1);
    else if (wr_i) wm_o <= wdata_i;
  end
endmodule

// File: rtl/ser_fifo_bank.sv
module ser_fifo_bank
  import ser_fifo_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  output logic [REG_W-1:0]  rdata_o,
  input  logic              eng_tx_pop_i,
  output logic [BYTE_W-1:0] eng_tx_data_o,
  input  logic              eng_rx_push_i,
  input  logic [BYTE_W-1:0] eng_rx_data_i,
  output logic              tx_below_wm_o,
  output logic              tx_full_o,
  output logic              tx_overflow_o,
  output logic              rx_not_empty_o
);
  localparam int WM_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic              wr_tx, wr_wm, rd_rx, rd_wm;
  logic              tx_empty, rx_full, rx_empty;
  logic [CNT_W-1:0]  tx_cnt, rx_cnt;
  logic [WM_W-1:0]   wm_q;
  logic [BYTE_W-1:0] rx_head;
  logic              ovf_q;
  logic              unused_hi;

  assign wr_tx = req_i &&  we_i && (addr_i == A_TXD);
  assign wr_wm = req_i &&  we_i && (addr_i == A_WM);
  assign rd_rx = req_i && !we_i && (addr_i == A_RXD);
  assign rd_wm = req_i && !we_i && (addr_i == A_WM);
  assign unused_hi = ^{wdata_i[REG_W-1:BYTE_W], tx_empty};

  ser_fifo_core #(.DEPTH(DEPTH), .W(BYTE_W)) u_tx (
    .clk_i, .rst_ni,
    .push_i(wr_tx), .din_i(wdata_i[BYTE_W-1:0]),
    .pop_i(eng_tx_pop_i), .dout_o(eng_tx_data_o),
    .full_o(tx_full_o), .empty_o(tx_empty), .count_o(tx_cnt)
  );

  ser_fifo_core #(.DEPTH(DEPTH), .W(BYTE_W)) u_rx (
    .clk_i, .rst_ni,
    .push_i(eng_rx_push_i), .din_i(eng_rx_data_i),
    .pop_i(rd_rx), .dout_o(rx_head),
    .full_o(rx_full), .empty_o(rx_empty), .count_o(rx_cnt)
  );

  ser_wm_reg #(.DEPTH(DEPTH)) u_wm (
    .clk_i, .rst_ni, .wr_i(wr_wm), .wdata_i(wdata_i[WM_W-1:0]), .wm_o(wm_q)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 ovf_q <= 1'b0;
    else if (wr_tx && tx_full_o) ovf_q <= 1'b1;
  end

  always_comb begin
    rdata_o = '0;
    if (rd_rx && !rx_empty) rdata_o = REG_W'(rx_head);
    else if (rd_wm)         rdata_o = REG_W'(wm_q);
  end

  assign tx_below_wm_o  = (tx_cnt < CNT_W'(wm_q));
  assign tx_overflow_o  = ovf_q;
  assign rx_not_empty_o = !rx_empty;

  logic unused_full;
  assign unused_full = rx_full;
endmodule

// File: rtl/ser_fifo_bank_chk.sv
module ser_fifo_bank_chk
  import ser_fifo_pkg::*;
#(
  parameter int DEPTH = 8,
  localparam int WM_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [REG_W-1:0]  wdata_i,
  input logic [REG_W-1:0]  rdata_o,
  input logic              eng_tx_pop_i,
  input logic              eng_rx_push_i,
  input logic              tx_full_o,
  input logic              tx_below_wm_o,
  input logic              tx_overflow_o,
  input logic              rx_not_empty_o,
  input logic [CNT_W-1:0]  tx_cnt,
  input logic [CNT_W-1:0]  rx_cnt,
  input logic [WM_W-1:0]   wm_q
);
  logic rd_rx_c, wr_tx_c, wr_wm_c;
  assign rd_rx_c = req_i && !we_i && (addr_i == A_RXD);
  assign wr_tx_c = req_i &&  we_i && (addr_i == A_TXD);
  assign wr_wm_c = req_i &&  we_i && (addr_i == A_WM);

  AST_WM_TRUNC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_wm_c |=> wm_q == $past(wdata_i[WM_W-1:0])); // R2

  AST_FULL_NOT_BELOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_o |-> !tx_below_wm_o); // R4

  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_tx_c && tx_full_o && !eng_tx_pop_i) |=> (tx_cnt == CNT_W'(DEPTH)) && tx_overflow_o); // R5

  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_overflow_o |=> tx_overflow_o); // R5

  AST_RX_POP_ONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx_c && rx_not_empty_o && !eng_rx_push_i) |=> rx_cnt == $past(rx_cnt) - 1'b1); // R7

  AST_EMPTY_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_rx_c && !rx_not_empty_o) |-> rdata_o == '0); // R8

  AST_RX_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rx_push_i && rx_cnt == CNT_W'(DEPTH) && !rd_rx_c) |=> rx_cnt == CNT_W'(DEPTH)); // R9
endmodule

bind ser_fifo_bank ser_fifo_bank_chk #(.DEPTH(DEPTH)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .wdata_i(wdata_i), .rdata_o(rdata_o), .eng_tx_pop_i(eng_tx_pop_i),
  .eng_rx_push_i(eng_rx_push_i), .tx_full_o(tx_full_o), .tx_below_wm_o(tx_below_wm_o),
  .tx_overflow_o(tx_overflow_o), .rx_not_empty_o(rx_not_empty_o),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt), .wm_q(wm_q)
);

// File: tb/ser_fifo_bank_tb.sv
module ser_fifo_bank_tb;
  localparam int DEPTH = 8;

  logic        clk_i = 0, rst_ni = 0;
  logic        req_i = 0, we_i = 0;
  logic [7:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic        eng_tx_pop_i = 0, eng_rx_push_i = 0;
  logic [7:0]  eng_tx_data_o, eng_rx_data_i = '0;
  logic        tx_below_wm_o, tx_full_o, tx_overflow_o, rx_not_empty_o;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  ser_fifo_bank #(.DEPTH(DEPTH)) u_dut (.*);

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic bus(input bit we, input logic [7:0] a, input logic [15:0] d,
                     output logic [15:0] rd);
    @(negedge clk_i);
    req_i = 1; we_i = we; addr_i = a; wdata_i = d;
    #2 rd = rdata_o;
    @(posedge clk_i); #1;
    req_i = 0; we_i = 0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] d);
    logic [15:0] x;
    bus(1'b1, a, d, x);
  endtask

  task automatic rd(input logic [7:0] a, output logic [15:0] v);
    bus(1'b0, a, 16'h0, v);
  endtask

  task automatic eng_pop(output logic [7:0] b);
    @(negedge clk_i);
    b = eng_tx_data_o;
    eng_tx_pop_i = 1;
    @(posedge clk_i); #1;
    eng_tx_pop_i = 0;
  endtask

  task automatic eng_push(input logic [7:0] b);
    @(negedge clk_i);
    eng_rx_push_i = 1; eng_rx_data_i = b;
    @(posedge clk_i); #1;
    eng_rx_push_i = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=0 exp=1");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] v;
    logic [7:0]  b;
    #23;
    // R3 reset state
    check("R3 below", tx_below_wm_o, 1);
    check("R3 full", tx_full_o, 0);
    check("R3 rxne", rx_not_empty_o, 0);
    check("R3 ovf", tx_overflow_o, 0);
    rst_ni = 1;
    #10;
    rd(8'h28, v); check("R3 wm reset", v, 1);

    // R2 truncation sweep
    for (int k = 0; k < 40; k++) begin
      logic [15:0] d;
      d = (k == 38) ? 16'hFFFF : (k == 39) ? 16'h1235 : 16'(k * 7);
      wr(8'h28, d);
      rd(8'h28, v);
      check("R2 wm readback", v, d % DEPTH);
    end

    // R1 decode
    wr(8'h28, 16'd1);
    rd(8'h1C, v); check("R1 read tx addr", v, 0);
    rd(8'h00, v); check("R1 read unmapped", v, 0);
    wr(8'h20, 16'h00AA);
    wr(8'h00, 16'h00BB);
    wr(8'h24, 16'h0003);
    check("R1 rx write no push", rx_not_empty_o, 0);
    check("R1 no tx push", tx_below_wm_o, 1);
    rd(8'h28, v); check("R1 wm untouched", v, 1);

    // R6 engine pop on empty ignored
    eng_pop(b);
    wr(8'h1C, 16'h0077);
    check("R6 one stored", tx_below_wm_o, 0);
    eng_pop(b); check("R6 data after empty pop", b, 8'h77);
    check("R6 empty again", tx_below_wm_o, 1);

    // R4 R5 R6 sweep watermark x occupancy
    for (int w = 0; w < DEPTH; w++) begin
      wr(8'h28, 16'(w));
      for (int n = 0; n <= DEPTH; n++) begin
        for (int i = 0; i < n; i++) wr(8'h1C, 16'((w * 16 + n + i * 3) & 8'hFF));
        check("R4 below", tx_below_wm_o, n < w);
        check("R5 full", tx_full_o, n == DEPTH);
        for (int i = 0; i < n; i++) begin
          eng_pop(b);
          check("R6 order", b, (w * 16 + n + i * 3) & 8'hFF);
        end
      end
    end
    check("R5 no ovf yet", tx_overflow_o, 0);

    // R7 R8 rx drain sweep
    for (int k = 0; k <= DEPTH; k++) begin
      for (int i = 0; i < k; i++) eng_push(8'((k * 20 + i * 5 + 1) & 8'hFF));
      check("R7 rxne", rx_not_empty_o, k > 0);
      for (int i = 0; i < k; i++) begin
        rd(8'h20, v);
        check("R7 rx data", v, (k * 20 + i * 5 + 1) & 8'hFF);
        check("R7 rxne drain", rx_not_empty_o, i < k - 1);
      end
      rd(8'h20, v); check("R8 empty read zero", v, 0);
      check("R8 still empty", rx_not_empty_o, 0);
    end
    eng_push(8'hA5);
    rd(8'h20, v); check("R8 pointers kept", v, 8'hA5);

    // R9 rx full drop
    for (int i = 0; i <= DEPTH; i++) eng_push(8'(8'h60 + i));
    for (int i = 0; i < DEPTH; i++) begin
      rd(8'h20, v); check("R9 kept order", v, 8'h60 + i);
    end
    check("R9 extra dropped", rx_not_empty_o, 0);

    // R6 R7 simultaneous engine exchange
    wr(8'h28, 16'd1);
    for (int i = 0; i < 3; i++) wr(8'h1C, 16'(8'h31 + i));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i);
      b = eng_tx_data_o;
      eng_tx_pop_i = 1; eng_rx_push_i = 1; eng_rx_data_i = b ^ 8'hFF;
      @(posedge clk_i); #1;
      eng_tx_pop_i = 0; eng_rx_push_i = 0;
      check("R6 exchange tx", b, 8'h31 + i);
    end
    for (int i = 0; i < 3; i++) begin
      rd(8'h20, v); check("R7 exchange rx", v, (8'h31 + i) ^ 8'hFF);
    end

    // R5 overflow
    for (int i = 0; i <= DEPTH; i++) wr(8'h1C, 16'(8'hC0 + i));
    check("R5 ovf set", tx_overflow_o, 1);
    check("R5 full", tx_full_o, 1);
    for (int i = 0; i < DEPTH; i++) begin
      eng_pop(b); check("R5 dropped byte absent", b, 8'hC0 + i);
    end
    check("R5 drained", tx_below_wm_o, 1);
    check("R5 ovf sticky", tx_overflow_o, 1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule